// File: doc/BRIEF.md
# Multi-Mode Logarithmic Barrel Shifter

This block shifts or rotates a 32-bit operand by any distance from 0 to 31 in a single combinational pass. The distance is applied as a cascade of fixed-distance stages, one per bit of the shift amount, with distances 1, 2, 4, 8 and 16. A stage either passes its input through or moves it by its own distance. A 2-bit operation code selects how each active stage moves its input: it can shift left with zero fill, shift right with zero fill, shift right with sign fill, or rotate right.

Alongside the result, the block produces a shifter carry. This is the last bit that left the operand during the shift. When the amount is zero, it is the incoming carry passed through unchanged. Each active stage replaces the carry it received with the bit it pushed out, so the carry from the final active stage is the one that reaches the output. The block has no clock and no state. It sits directly in an execute-stage datapath, between operand selection and the ALU or the result bus.

Top module: `barrel_shifter`

## Requirements
- R1: When `amt_i` is 0, `result_o` equals `operand_i` and `carry_o` equals `carry_i`, for every operation code.
- R2: With `op_i` = 2'b00 (shift left) and `amt_i` = n, `result_o` equals `operand_i` shifted left by n, and bits n-1..0 are zero.
- R3: With `op_i` = 2'b00 and n > 0, `carry_o` equals `operand_i[32-n]`.
- R4: With `op_i` = 2'b01 (logical shift right) and n > 0, `result_o` equals `operand_i` shifted right by n, the top n bits are zero, and `carry_o` equals `operand_i[n-1]`.
- R5: With `op_i` = 2'b10 (arithmetic shift right) and n > 0, the top n bits of `result_o` copy `operand_i[31]`, the lower 32-n bits equal `operand_i[31:n]`, and `carry_o` equals `operand_i[n-1]`.
- R6: With `op_i` = 2'b11 (rotate right) and n > 0, `result_o` equals `operand_i` rotated right by n, and `carry_o` equals `result_o[31]`, which is `operand_i[n-1]`.
- R7: When `amt_i` is nonzero, `carry_i` has no effect on either `result_o` or `carry_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 32 | Value to be shifted or rotated |
| amt_i | input | 5 | Shift distance, 0 to 31 |
| op_i | input | 2 | Operation: 00 shift left, 01 logical right, 10 arithmetic right, 11 rotate right |
| carry_i | input | 1 | Carry passed through when the distance is zero |
| result_o | output | 32 | Shifted or rotated value |
| carry_o | output | 1 | Last bit shifted out, or `carry_i` when the distance is zero |

## Verification
The bench targets the following corner cases:

- **Zero distance on all four operations.** A design that let a stage act with its enable low, or that dropped the incoming carry, would change the result or lose `carry_i`.
- **Distances 1 and 31, and distances that light several stages.** A carry taken from the first active stage instead of the last would report a bit from the wrong position.
- **Arithmetic shifts of negative operands.** A design that fills from the current stage input instead of bit 31, or fills with zeros, would clear the sign bits.
- **Rotates.** The bench checks that the carry matches the bit landing in bit 31, and that `carry_i` is ignored on a nonzero shift.

// File: rtl/barrel_shifter_pkg.sv
package barrel_shifter_pkg;

  typedef enum logic [1:0] {
    OP_LSL = 2'b00,
    OP_LSR = 2'b01,
    OP_ASR = 2'b10,
    OP_ROR = 2'b11
  } shift_op_e;

  // One-hot stage select, decoded once and shared by every stage
  typedef struct packed {
    logic lsl;
    logic lsr;
    logic asr;
    logic ror;
  } shift_sel_t;

endpackage

// File: rtl/barrel_shifter_decode.sv
module barrel_shifter_decode
  import barrel_shifter_pkg::*;
(
  input  logic [1:0] op_i,
  input  logic       msb_i,
  output shift_sel_t sel_o,
  output logic       fill_o
);

  always_comb begin
    sel_o = '0;
    unique case (shift_op_e'(op_i))
      OP_LSL:  sel_o.lsl = 1'b1;
      OP_LSR:  sel_o.lsr = 1'b1;
      OP_ASR:  sel_o.asr = 1'b1;
      default: sel_o.ror = 1'b1;
    endcase
  end

  // Sign fill comes from the original operand, not from a stage input
  assign fill_o = sel_o.asr & msb_i;

endmodule

// File: rtl/barrel_shifter_stage.sv
module barrel_shifter_stage
  import barrel_shifter_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIST   = 1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              carry_i,
  input  logic              en_i,
  input  logic              fill_i,
  input  shift_sel_t        sel_i,
  output logic [DATA_W-1:0] data_o,
  output logic              carry_o
);

  localparam int KEEP_W = DATA_W - DIST;

  logic [DATA_W-1:0] lsl_d, lsr_d, asr_d, ror_d;

  assign lsl_d = {data_i[KEEP_W-1:0], {DIST{1'b0}}};
  assign lsr_d = {{DIST{1'b0}}, data_i[DATA_W-1:DIST]};
  assign asr_d = {{DIST{fill_i}}, data_i[DATA_W-1:DIST]};
  assign ror_d = {data_i[DIST-1:0], data_i[DATA_W-1:DIST]};

  // Five-way select: pass or one of four moved copies; an active stage owns the carry
  always_comb begin
    data_o  = data_i;
    carry_o = carry_i;
    if (en_i) begin
      unique case (1'b1)
        sel_i.lsl: begin data_o = lsl_d; carry_o = data_i[KEEP_W];  end
        sel_i.lsr: begin data_o = lsr_d; carry_o = data_i[DIST-1];  end
        sel_i.asr: begin data_o = asr_d; carry_o = data_i[DIST-1];  end
        default:   begin data_o = ror_d; carry_o = data_i[DIST-1];  end
      endcase
    end
  end

endmodule

// File: rtl/barrel_shifter.sv
module barrel_shifter
  import barrel_shifter_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]         operand_i,
  input  logic [$clog2(DATA_W)-1:0] amt_i,
  input  logic [1:0]                op_i,
  input  logic                      carry_i,
  output logic [DATA_W-1:0]         result_o,
  output logic                      carry_o
);

  localparam int AMT_W = $clog2(DATA_W);

  shift_sel_t        sel;
  logic              fill;
  logic [DATA_W-1:0] data_q [AMT_W+1];
  logic              cy_q   [AMT_W+1];

  barrel_shifter_decode u_decode (
    .op_i   (op_i),
    .msb_i  (operand_i[DATA_W-1]),
    .sel_o  (sel),
    .fill_o (fill)
  );

  assign data_q[0] = operand_i;
  assign cy_q[0]   = carry_i;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    barrel_shifter_stage #(
      .DATA_W (DATA_W),
      .DIST   (1 << k)
    ) u_stage (
      .data_i  (data_q[k]),
      .carry_i (cy_q[k]),
      .en_i    (amt_i[k]),
      .fill_i  (fill),
      .sel_i   (sel),
      .data_o  (data_q[k+1]),
      .carry_o (cy_q[k+1])
    );
  end

  assign result_o = data_q[AMT_W];
  assign carry_o  = cy_q[AMT_W];

endmodule

// File: rtl/barrel_shifter_chk.sv
module barrel_shifter_chk #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 5
) (
  input logic [DATA_W-1:0] operand_i,
  input logic [AMT_W-1:0]  amt_i,
  input logic [1:0]        op_i,
  input logic              carry_i,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o
);

  logic [DATA_W-1:0] lo_mask, hi_mask;
  int n;

  always_comb begin
    n       = int'(amt_i);
    lo_mask = (DATA_W'(1) << amt_i) - DATA_W'(1);
    hi_mask = ~({DATA_W{1'b1}} >> amt_i);
  end

  always_comb begin
    if (n == 0) begin
      assert_zero_amt_R1: assert (result_o == operand_i && carry_o == carry_i);
    end else begin
      if (op_i == 2'b00) begin
        assert_lsl_zero_fill_R2: assert ((result_o & lo_mask) == '0);
        assert_lsl_carry_R3: assert (carry_o == operand_i[DATA_W - n]);
      end
      if (op_i == 2'b01) begin
        assert_lsr_zero_fill_R4: assert ((result_o & hi_mask) == '0 && carry_o == operand_i[n-1]);
      end
      if (op_i == 2'b10) begin
        assert_asr_sign_fill_R5: assert ((result_o & hi_mask) == (operand_i[DATA_W-1] ? hi_mask : '0)
                                         && result_o[DATA_W-1] == operand_i[DATA_W-1]);
      end
      if (op_i == 2'b11) begin
        assert_ror_bits_kept_R6: assert ($countones(result_o) == $countones(operand_i)
                                         && carry_o == result_o[DATA_W-1]);
      end
    end
  end

endmodule

bind barrel_shifter barrel_shifter_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (.*);

// File: tb/barrel_shifter_bench.sv
module barrel_shifter_bench;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] operand;
  logic [4:0]  amt;
  logic [1:0]  op;
  logic        cin;
  logic [31:0] result;
  logic        cout;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  barrel_shifter u_barrel_shifter (
    .operand_i (operand),
    .amt_i     (amt),
    .op_i      (op),
    .carry_i   (cin),
    .result_o  (result),
    .carry_o   (cout)
  );

  // Reference: one-bit steps, amt times
  function automatic logic [32:0] ref_model(logic [31:0] x, logic [1:0] o, logic [4:0] a, logic c);
    logic [31:0] r = x;
    logic        cy = c;
    for (int i = 0; i < int'(a); i++) begin
      case (o)
        2'b00:   begin cy = r[31]; r = {r[30:0], 1'b0};  end
        2'b01:   begin cy = r[0];  r = {1'b0, r[31:1]};  end
        2'b10:   begin cy = r[0];  r = {r[31], r[31:1]}; end
        default: begin cy = r[0];  r = {r[0], r[31:1]};  end
      endcase
    end
    return {cy, r};
  endfunction

  task automatic apply(logic [31:0] x, logic [1:0] o, logic [4:0] a, logic c);
    @(negedge clk);
    operand = x; op = o; amt = a; cin = c;
    #1;
  endtask

  task automatic check(string req, logic [31:0] exp_r, logic exp_c);
    n_tests++;
    if (result !== exp_r || cout !== exp_c) begin
      n_fail++;
      $display("FAIL %s op=%0d amt=%0d x=%h: got %h/%0b exp %h/%0b",
               req, op, amt, operand, result, cout, exp_r, exp_c);
    end
  endtask

  task automatic run_ref(string req, logic [31:0] x, logic [1:0] o, logic [4:0] a, logic c);
    logic [32:0] e;
    apply(x, o, a, c);
    e = ref_model(x, o, a, c);
    check(req, e[31:0], e[32]);
  endtask

  task automatic t_zero_amt();  // R1
    for (int o = 0; o < 4; o++) begin
      apply(32'h8000_0001, 2'(o), 5'd0, 1'b1);
      check("R1", 32'h8000_0001, 1'b1);
      apply(32'h7FFF_FFFE, 2'(o), 5'd0, 1'b0);
      check("R1", 32'h7FFF_FFFE, 1'b0);
    end
  endtask

  task automatic t_lsl();  // R2 R3
    apply(32'h0000_0001, 2'b00, 5'd31, 1'b0);
    check("R2", 32'h8000_0000, 1'b0);
    apply(32'h8000_0001, 2'b00, 5'd1, 1'b0);
    check("R3", 32'h0000_0002, 1'b1);
    apply(32'h1234_5678, 2'b00, 5'd12, 1'b0);
    check("R2", 32'h4567_8000, 1'b1);
    apply(32'h0000_0002, 2'b00, 5'd31, 1'b1);
    check("R3", 32'h0000_0000, 1'b1);
  endtask

  task automatic t_lsr();  // R4
    apply(32'hFFFF_FFFF, 2'b01, 5'd31, 1'b0);
    check("R4", 32'h0000_0001, 1'b1);
    apply(32'h8000_0002, 2'b01, 5'd1, 1'b1);
    check("R4", 32'h4000_0001, 1'b0);
    apply(32'hABCD_0080, 2'b01, 5'd8, 1'b0);
    check("R4", 32'h00AB_CD00, 1'b1);
  endtask

  task automatic t_asr();  // R5
    apply(32'h8000_0000, 2'b10, 5'd31, 1'b1);
    check("R5", 32'hFFFF_FFFF, 1'b0);
    apply(32'hF000_0010, 2'b10, 5'd5, 1'b0);
    check("R5", 32'hFF80_0000, 1'b1);
    apply(32'h7000_0003, 2'b10, 5'd2, 1'b0);
    check("R5", 32'h1C00_0000, 1'b1);
  endtask

  task automatic t_ror();  // R6
    apply(32'h0000_0001, 2'b11, 5'd1, 1'b0);
    check("R6", 32'h8000_0000, 1'b1);
    apply(32'h1234_5678, 2'b11, 5'd16, 1'b1);
    check("R6", 32'h5678_1234, 1'b0);
    apply(32'h8000_0000, 2'b11, 5'd31, 1'b0);
    check("R6", 32'h0000_0001, 1'b0);
  endtask

  task automatic t_carry_in_ignored();  // R7
    for (int o = 0; o < 4; o++) begin
      run_ref("R7", 32'h5A5A_F00F, 2'(o), 5'd7, 1'b1);
      run_ref("R7", 32'h5A5A_F00F, 2'(o), 5'd7, 1'b0);
    end
  endtask

  task automatic t_sweep();  // R2 R3 R4 R5 R6 over all amounts
    for (int o = 0; o < 4; o++)
      for (int a = 0; a < 32; a++)
        for (int r = 0; r < 8; r++)
          run_ref(a == 0 ? "R1" : "R2_R6_sweep", $urandom(), 2'(o), 5'(a), 1'($urandom()));
  endtask

  initial begin
    operand = '0; amt = '0; op = '0; cin = 1'b0;
    void'($urandom(32'd1234));
    #10 rst_ni = 1'b1;
    apply(32'hC3C3_3C3C, 2'b00, 5'd0, 1'b0);
    check("R1", 32'hC3C3_3C3C, 1'b0);
    t_zero_amt();
    t_lsl();
    t_lsr();
    t_asr();
    t_ror();
    t_carry_in_ignored();
    t_sweep();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule